// File: doc/BRIEF.md
# Receive descriptor ring engine

This block stores an incoming byte stream into receive buffers that a host lays out through a ring of descriptors. The descriptors sit in a small memory inside the block, and the host reads and writes it one 32-bit word at a time. Each frame arrives as a sequence of byte beats. Start-of-frame and end-of-frame markers frame it, and an error flag may come with any beat. When a frame starts, the engine takes the current descriptor if the host owns nothing there, that is, if the descriptor is armed. It then writes the bytes out through a byte-wide buffer write port, starting at the descriptor's buffer address. On the end beat it stores the byte count and the error status, returns the descriptor to the host, and steps to the next descriptor in the ring.

A receive-enable bit gates all of this. The host sets it with a one-cycle pulse. The engine clears it when a frame meets a descriptor the host has not armed. A frame that is not accepted is discarded whole and counted. The host re-arms a descriptor by setting its active bit again, and it sets the enable again when it finds the enable clear.

Top module: `rxr_ring_engine`

## Requirements
- R1: Each descriptor is three words, selected by host address {index, word} with word 0 to 2. Word 0 holds the flags: active at bit 31, end-of-ring at bit 30, frame-error at bit 29. Word 1 holds the buffer size in bits 31:16 and the stored length in bits 15:0. Word 2 holds the buffer address. Every word reads as zero after reset, and word 3 reads as zero.
- R2: When a frame is accepted, byte k of the frame appears on the buffer port with write enable, address base+k and the byte value, one cycle after its input beat.
- R3: On the end beat of an accepted frame, the engine clears the active bit and writes the stored byte count into word 1 bits 15:0. It leaves the end-of-ring bit, the other word-0 bits and the size field unchanged. The change is visible to the host from the next cycle.
- R4: Bytes past the buffer size are not written. The stored length then equals the size and the frame-error bit is set. A size of zero stores nothing.
- R5: An error flag on any beat of an accepted frame sets the frame-error bit. A clean frame that fits completes with the bit clear.
- R6: After a completion the next descriptor is index 0 if the completed one had its end-of-ring bit set, and otherwise the next index, modulo the ring depth.
- R7: The low ALIGN bits (5 by default) of the buffer address are treated as zero.
- R8: If the enable is set and the current descriptor is not active when a frame starts, the engine writes no byte and changes no descriptor. It clears the enable and adds one to the drop counter.
- R9: The enable is clear after reset and is set by a request pulse. While it is clear, every starting frame is discarded and counted, and no descriptor changes. A request pulse in the same cycle as a clearing drop leaves the enable set.
- R10: A frame may start on the beat right after the previous frame's end beat, and it uses the next descriptor. A single-beat frame, with start and end on the same beat, completes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte beat valid |
| in_sof | input | 1 | First beat of a frame |
| in_eof | input | 1 | Last beat of a frame |
| in_err | input | 1 | Error reported on this beat |
| in_data | input | 8 | Input byte |
| req_set | input | 1 | Pulse that sets the receive enable |
| rx_req | output | 1 | Receive enable state |
| drop_cnt | output | CNT_W | Saturating count of discarded frames |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Buffer byte address |
| buf_data | output | 8 | Buffer byte value |
| hst_we | input | 1 | Host descriptor word write |
| hst_addr | input | IDXW+2 | Host word address {index, word} |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, combinational |

## Verification
Two functions can fall in the same cycle. One is the host pulsing the receive enable. The other is the engine clearing that enable because a new frame meets a descriptor that is not armed. The bench provokes this by driving the request pulse on the start beat of a frame aimed at a descriptor that was already completed. It expects the enable to read set on the next cycle while the drop counter still advances and no descriptor word changes. A behavioural model predicts every buffer write, the enable and the counter cycle by cycle, and it catches the end-of-frame completion landing in the same cycle as a new start on back-to-back frames.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int ACT_BIT  = 31;
   localparam int EOR_BIT  = 30;
   localparam int FERR_BIT = 29;
   localparam int HALF_W   = 16;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_SKIP = 2'd2
   } rxr_state_e;
endpackage

// File: rtl/rxr_desc_ram.sv
module rxr_desc_ram #(
   parameter int NDESC = 8,
   parameter int IDXW  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_we,
   input  logic [IDXW+1:0]   hst_addr,
   input  logic [31:0]       hst_wdata,
   output logic [31:0]       hst_rdata,
   input  logic [IDXW-1:0]   cur_idx,
   output logic              cur_act,
   output logic              cur_eor,
   output logic [15:0]       cur_size,
   output logic [31:0]       cur_addr,
   input  logic              cmp_we,
   input  logic              cmp_ferr,
   input  logic [15:0]       cmp_len
);
   import rxr_pkg::*;

   logic [31:0] w0_a [NDESC];
   logic [31:0] w1_a [NDESC];
   logic [31:0] w2_a [NDESC];

   for (genvar d = 0; d < NDESC; d++) begin : g_ent
      logic [31:0] w0_r, w1_r, w2_r;
      logic        sel, h0, h1, h2;
      assign sel = (cur_idx == IDXW'(d));
      assign h0  = hst_we && (hst_addr == {IDXW'(d), 2'd0});
      assign h1  = hst_we && (hst_addr == {IDXW'(d), 2'd1});
      assign h2  = hst_we && (hst_addr == {IDXW'(d), 2'd2});
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            w0_r <= '0;
            w1_r <= '0;
            w2_r <= '0;
         end else begin
            if (h0)
               w0_r <= hst_wdata;
            else if (cmp_we && sel)
               w0_r <= {1'b0, w0_r[EOR_BIT], cmp_ferr, w0_r[FERR_BIT-1:0]};
            if (h1)
               w1_r <= hst_wdata;
            else if (cmp_we && sel)
               w1_r <= {w1_r[31:HALF_W], cmp_len};
            if (h2)
               w2_r <= hst_wdata;
         end
      end
      assign w0_a[d] = w0_r;
      assign w1_a[d] = w1_r;
      assign w2_a[d] = w2_r;
   end

   logic [IDXW-1:0] h_ent;
   assign h_ent = hst_addr[IDXW+1:2];

   always_comb begin
      hst_rdata = '0;
      if (int'(h_ent) < NDESC) begin
         case (hst_addr[1:0])
            2'd0:    hst_rdata = w0_a[h_ent];
            2'd1:    hst_rdata = w1_a[h_ent];
            2'd2:    hst_rdata = w2_a[h_ent];
            default: hst_rdata = '0;
         endcase
      end
   end

   assign cur_act  = w0_a[cur_idx][ACT_BIT];
   assign cur_eor  = w0_a[cur_idx][EOR_BIT];
   assign cur_size = w1_a[cur_idx][31:HALF_W];
   assign cur_addr = w2_a[cur_idx];

   // completion hands the descriptor back unless the host overwrote word 0
   logic            chk_cmp_q, chk_hit_q;
   logic [IDXW-1:0] chk_idx_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_cmp_q <= 1'b0;
         chk_hit_q <= 1'b0;
         chk_idx_q <= '0;
      end else begin
         chk_cmp_q <= cmp_we;
         chk_hit_q <= hst_we && (hst_addr == {cur_idx, 2'd0});
         chk_idx_q <= cur_idx;
      end
   end

   p_act_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_cmp_q && !chk_hit_q) |-> !w0_a[chk_idx_q][ACT_BIT]);
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
   parameter int NDESC = 8,
   parameter int IDXW  = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv,
   input  logic            eor,
   output logic [IDXW-1:0] idx
);
   logic [IDXW-1:0] idx_q, nxt;

   if (NDESC == (1 << IDXW)) begin : g_pow2
      assign nxt = idx_q + 1'b1;
   end else begin : g_cmp
      assign nxt = (idx_q == IDXW'(NDESC - 1)) ? '0 : idx_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         idx_q <= '0;
      else if (adv)
         idx_q <= eor ? '0 : nxt;
   end

   assign idx = idx_q;

   p_eor_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && eor) |=> (idx_q == '0));
   p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !eor && idx_q != IDXW'(NDESC - 1)) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/rxr_fill_ctl.sv
module rxr_fill_ctl #(
   parameter int ALIGN = 5,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eof,
   input  logic             in_err,
   input  logic [7:0]       in_data,
   input  logic             req_set,
   input  logic             cur_act,
   input  logic [15:0]      cur_size,
   input  logic [31:ALIGN]  cur_addr_hi,
   output logic             buf_we,
   output logic [31:0]      buf_addr,
   output logic [7:0]       buf_data,
   output logic             cmp_we,
   output logic             cmp_ferr,
   output logic [15:0]      cmp_len,
   output logic             rx_req,
   output logic [CNT_W-1:0] drop_cnt
);
   import rxr_pkg::*;

   rxr_state_e       st_q, st_n;
   logic [31:0]      base_q, base_n;
   logic [15:0]      size_q, size_n, cnt_q, cnt_c, cnt_nx;
   logic             err_q, err_c, ovf_q, ovf_c;
   logic             req_q;
   logic [CNT_W-1:0] drop_q;
   logic             start, take, drop, in_frame, room, wr;

   assign start    = in_valid && in_sof && (st_q == ST_IDLE);
   assign take     = start && req_q && cur_act;
   assign drop     = start && !take;
   assign in_frame = take || (in_valid && st_q == ST_FILL);

   assign base_n = take ? {cur_addr_hi, {ALIGN{1'b0}}} : base_q;
   assign size_n = take ? cur_size : size_q;
   assign cnt_c  = take ? '0 : cnt_q;
   assign err_c  = take ? 1'b0 : err_q;
   assign ovf_c  = take ? 1'b0 : ovf_q;
   assign room   = cnt_c < size_n;
   assign wr     = in_frame && room;
   assign cnt_nx = cnt_c + 16'(wr);

   assign cmp_we   = in_frame && in_eof;
   assign cmp_len  = cnt_nx;
   assign cmp_ferr = err_c || in_err || ovf_c || !room;

   always_comb begin
      st_n = st_q;
      case (st_q)
         ST_IDLE: if (take && !in_eof) st_n = ST_FILL;
                  else if (drop && !in_eof) st_n = ST_SKIP;
         ST_FILL: if (in_valid && in_eof) st_n = ST_IDLE;
         ST_SKIP: if (in_valid && in_eof) st_n = ST_IDLE;
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         base_q   <= '0;
         size_q   <= '0;
         cnt_q    <= '0;
         err_q    <= 1'b0;
         ovf_q    <= 1'b0;
         req_q    <= 1'b0;
         drop_q   <= '0;
         buf_we   <= 1'b0;
         buf_addr <= '0;
         buf_data <= '0;
      end else begin
         st_q   <= st_n;
         base_q <= base_n;
         size_q <= size_n;
         if (in_frame) begin
            cnt_q <= cnt_nx;
            err_q <= err_c || in_err;
            ovf_q <= ovf_c || !room;
         end
         if (req_set)
            req_q <= 1'b1;
         else if (drop && req_q)
            req_q <= 1'b0;
         if (drop && drop_q != '1)
            drop_q <= drop_q + 1'b1;
         buf_we   <= wr;
         buf_addr <= base_n + {16'd0, cnt_c};
         buf_data <= in_data;
      end
   end

   assign rx_req   = req_q;
   assign drop_cnt = drop_q;

   // offset of the last written byte, kept for the bounds check
   logic [15:0] chk_off_q;
   always_ff @(posedge clk) begin
      if (!rst_n) chk_off_q <= '0;
      else        chk_off_q <= cnt_c;
   end

   p_in_bounds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      buf_we |-> (chk_off_q < size_q));
   p_len_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_we |-> (cmp_len <= size_n));
   p_drop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (drop && req_q && !req_set) |=> !rx_req);
   p_drop_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (drop && drop_q != '1) |=> (drop_cnt == $past(drop_cnt) + 1'b1));
   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_set |=> rx_req);
endmodule

// File: rtl/rxr_ring_engine.sv
module rxr_ring_engine #(
   parameter  int NDESC = 8,
   parameter  int ALIGN = 5,
   parameter  int CNT_W = 16,
   localparam int IDXW  = (NDESC > 1) ? $clog2(NDESC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sof,
   input  logic             in_eof,
   input  logic             in_err,
   input  logic [7:0]       in_data,
   input  logic             req_set,
   output logic             rx_req,
   output logic [CNT_W-1:0] drop_cnt,
   output logic             buf_we,
   output logic [31:0]      buf_addr,
   output logic [7:0]       buf_data,
   input  logic             hst_we,
   input  logic [IDXW+1:0]  hst_addr,
   input  logic [31:0]      hst_wdata,
   output logic [31:0]      hst_rdata
);
   if (NDESC < 2) begin : g_bad_depth
      $error("rxr_ring_engine: NDESC must be at least 2");
   end
   if (ALIGN < 1 || ALIGN > 12) begin : g_bad_align
      $error("rxr_ring_engine: ALIGN must lie in 1..12");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("rxr_ring_engine: CNT_W must lie in 1..32");
   end

   logic [IDXW-1:0] cur_idx;
   logic            cur_act, cur_eor, cmp_we, cmp_ferr;
   logic [15:0]     cur_size, cmp_len;
   logic [31:0]     cur_addr;

   rxr_desc_ram #(.NDESC(NDESC), .IDXW(IDXW)) u_ram (
      .clk(clk), .rst_n(rst_n),
      .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
      .cur_idx(cur_idx), .cur_act(cur_act), .cur_eor(cur_eor),
      .cur_size(cur_size), .cur_addr(cur_addr),
      .cmp_we(cmp_we), .cmp_ferr(cmp_ferr), .cmp_len(cmp_len)
   );

   rxr_ring_ptr #(.NDESC(NDESC), .IDXW(IDXW)) u_ptr (
      .clk(clk), .rst_n(rst_n), .adv(cmp_we), .eor(cur_eor), .idx(cur_idx)
   );

   logic [ALIGN-1:0] addr_lo_unused;
   assign addr_lo_unused = cur_addr[ALIGN-1:0];

   rxr_fill_ctl #(.ALIGN(ALIGN), .CNT_W(CNT_W)) u_fill (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err), .in_data(in_data),
      .req_set(req_set),
      .cur_act(cur_act), .cur_size(cur_size), .cur_addr_hi(cur_addr[31:ALIGN]),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
      .cmp_we(cmp_we), .cmp_ferr(cmp_ferr), .cmp_len(cmp_len),
      .rx_req(rx_req), .drop_cnt(drop_cnt)
   );

   p_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof && rx_req && cur_act && cur_size != 16'd0) |=>
      (buf_we && buf_addr[ALIGN-1:0] == '0));
endmodule

// File: tb/rxr_ring_engine_test.sv
`timescale 1ns/1ps
module rxr_ring_engine_test;
   localparam int N = 8;
   localparam int IDXW = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 0, in_sof = 0, in_eof = 0, in_err = 0;
   logic [7:0]  in_data = '0;
   logic        req_set = 0;
   logic        rx_req;
   logic [15:0] drop_cnt;
   logic        buf_we;
   logic [31:0] buf_addr;
   logic [7:0]  buf_data;
   logic        hst_we = 0;
   logic [IDXW+1:0] hst_addr = '0;
   logic [31:0] hst_wdata = '0;
   logic [31:0] hst_rdata;

   rxr_ring_engine #(.NDESC(N)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
      .in_err(in_err), .in_data(in_data), .req_set(req_set), .rx_req(rx_req),
      .drop_cnt(drop_cnt), .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
      .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata)
   );

   always #2.5 clk = ~clk;

   int checks = 0, fails = 0;
   bit done = 0, cmp_en = 0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // behavioural reference model
   logic [31:0] mm [N*4];
   int          m_idx, m_st, m_n, m_size, m_drop;
   logic [31:0] m_base;
   bit          m_err, m_ovf, m_req, e_we;
   logic [31:0] e_addr;
   logic [7:0]  e_data;

   task automatic byte_in();
      if (m_n < m_size) begin
         e_we = 1; e_addr = m_base + m_n; e_data = in_data; m_n++;
      end else m_ovf = 1;
   endtask

   task automatic finish_frame();
      logic [31:0] w;
      w = mm[m_idx*4];
      mm[m_idx*4] = (w & ~32'hA000_0000) | ((m_err || m_ovf) ? 32'h2000_0000 : 32'h0);
      mm[m_idx*4+1] = {mm[m_idx*4+1][31:16], 16'(m_n)};
      m_idx = w[30] ? 0 : (m_idx + 1) % N;
      m_st = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N*4; i++) mm[i] = '0;
         m_idx = 0; m_st = 0; m_req = 0; m_drop = 0; e_we = 0; m_n = 0; m_size = 0;
      end else begin
         bit clr;
         clr = 0; e_we = 0;
         if (in_valid) begin
            if (m_st == 0) begin
               if (in_sof) begin
                  if (m_req && mm[m_idx*4][31]) begin
                     m_base = mm[m_idx*4+2] & 32'hFFFF_FFE0;
                     m_size = int'(mm[m_idx*4+1][31:16]);
                     m_n = 0; m_err = in_err; m_ovf = 0;
                     byte_in();
                     if (in_eof) finish_frame(); else m_st = 1;
                  end else begin
                     if (m_drop < 65535) m_drop++;
                     if (m_req) clr = 1;
                     if (!in_eof) m_st = 2;
                  end
               end
            end else if (m_st == 1) begin
               m_err = m_err | in_err;
               byte_in();
               if (in_eof) finish_frame();
            end else if (in_eof) m_st = 0;
         end
         if (req_set) m_req = 1; else if (clr) m_req = 0;
         if (hst_we && hst_addr[1:0] != 2'd3) mm[hst_addr] = hst_wdata;
      end
   end

   always @(negedge clk) begin
      if (cmp_en) begin
         chk("R2 buf_we", {31'd0, buf_we}, {31'd0, e_we});
         if (e_we) begin
            chk("R2 R7 buf_addr", buf_addr, e_addr);
            chk("R2 buf_data", {24'd0, buf_data}, {24'd0, e_data});
         end
         chk("R9 rx_req", {31'd0, rx_req}, {31'd0, m_req});
         chk("R8 drop_cnt", {16'd0, drop_cnt}, 32'(m_drop));
      end
   end

   task automatic clear_in();
      in_valid = 0; in_sof = 0; in_eof = 0; in_err = 0; in_data = '0;
      req_set = 0; hst_we = 0;
   endtask

   task automatic idle(int n);
      repeat (n) begin @(negedge clk); #1; clear_in(); end
   endtask

   task automatic wr(int idx, int word, logic [31:0] d);
      @(negedge clk); #1; clear_in();
      hst_we = 1; hst_addr = {IDXW'(idx), 2'(word)}; hst_wdata = d;
   endtask

   task automatic pulse_req();
      @(negedge clk); #1; clear_in(); req_set = 1;
   endtask

   task automatic frame(int len, int errpos, logic [7:0] seed, bit set_first);
      for (int i = 0; i < len; i++) begin
         @(negedge clk); #1; clear_in();
         in_valid = 1; in_sof = (i == 0); in_eof = (i == len - 1);
         in_err = (i == errpos); in_data = seed + 8'(i);
         req_set = set_first && (i == 0);
      end
   endtask

   task automatic rd(string req, int idx, int word, logic [31:0] exp);
      @(negedge clk); #1; clear_in();
      hst_addr = {IDXW'(idx), 2'(word)};
      #1 chk(req, hst_rdata, exp);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk); #1; rst_n = 1;
      @(posedge clk); #1; cmp_en = 1;
      chk("R9 reset rx_req", {31'd0, rx_req}, 32'd0);
      chk("R8 reset drop_cnt", {16'd0, drop_cnt}, 32'd0);
      chk("R2 reset buf_we", {31'd0, buf_we}, 32'd0);
      rd("R1 reset word0", 0, 0, 32'h0);
      rd("R1 reset word1", 3, 1, 32'h0);

      for (int i = 0; i < N; i++) begin
         wr(i, 1, 32'h0010_0000);
         wr(i, 2, 32'h1000 + 32'(i) * 256);
         wr(i, 0, 32'h8000_0000);
      end
      wr(0, 0, 32'h8000_0001);
      wr(2, 1, 32'h0004_0000);
      wr(3, 2, 32'h0000_1317);
      wr(5, 0, 32'hC000_0000);
      rd("R1 word2 readback", 4, 2, 32'h0000_1400);
      rd("R1 word3 reads zero", 4, 3, 32'h0);
      pulse_req();
      idle(1);

      frame(5, -1, 8'h10, 0); idle(1);
      rd("R1 R3 desc0 flags kept, active cleared", 0, 0, 32'h0000_0001);
      rd("R3 desc0 length", 0, 1, 32'h0010_0005);

      frame(6, 2, 8'h20, 0); idle(1);
      rd("R5 desc1 error flag", 1, 0, 32'h2000_0000);
      rd("R5 desc1 length", 1, 1, 32'h0010_0006);

      frame(7, -1, 8'h30, 0); idle(1);
      rd("R4 desc2 overflow flag", 2, 0, 32'h2000_0000);
      rd("R4 desc2 length capped", 2, 1, 32'h0004_0004);

      frame(3, -1, 8'h40, 0); idle(1);
      rd("R7 desc3 clean", 3, 0, 32'h0);
      rd("R7 desc3 length", 3, 1, 32'h0010_0003);

      frame(2, -1, 8'h50, 0);
      frame(1, -1, 8'h60, 0); idle(1);
      rd("R10 desc4 length", 4, 1, 32'h0010_0002);
      rd("R10 R3 desc5 end-of-ring kept", 5, 0, 32'h4000_0000);
      rd("R10 desc5 single beat length", 5, 1, 32'h0010_0001);

      frame(4, -1, 8'h70, 0); idle(1);
      chk("R8 enable cleared", {31'd0, rx_req}, 32'd0);
      chk("R8 drop counted", {16'd0, drop_cnt}, 32'd1);
      rd("R8 desc0 untouched", 0, 0, 32'h0000_0001);
      rd("R8 desc0 length untouched", 0, 1, 32'h0010_0005);

      wr(0, 0, 32'h8000_0000);
      frame(3, -1, 8'h80, 0); idle(1);
      chk("R9 disabled drop counted", {16'd0, drop_cnt}, 32'd2);
      rd("R9 desc0 still armed", 0, 0, 32'h8000_0000);

      pulse_req();
      frame(2, -1, 8'h90, 0); idle(1);
      rd("R6 wrap to desc0", 0, 0, 32'h0);
      rd("R6 desc0 length", 0, 1, 32'h0010_0002);

      frame(1, -1, 8'hA0, 1); idle(1);
      chk("R9 set wins over clear", {31'd0, rx_req}, 32'd1);
      chk("R8 concurrent drop counted", {16'd0, drop_cnt}, 32'd3);
      rd("R8 desc1 unchanged", 1, 0, 32'h2000_0000);

      wr(1, 1, 32'h0);
      wr(1, 0, 32'h8000_0000);
      frame(2, -1, 8'hB0, 0); idle(1);
      rd("R4 zero size flag", 1, 0, 32'h2000_0000);
      rd("R4 zero size length", 1, 1, 32'h0);

      idle(3);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule